// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the effective operand address for an 8-bit processor core with a 16-bit address space. A request begins with a one-cycle `start`. In that cycle the block takes the addressing mode, the prebyte flag, the immediate width, the index select, the branch condition, the program counter and both index registers. After that it accepts the operand bytes that follow the opcode, at most one per cycle, each marked by `opnd_valid`. When it has every byte the mode needs, it publishes the 16-bit effective address and the instruction length in bytes, and pulses `done` for one cycle.

The `pc` input is the address of the first byte of the instruction, which is the prebyte when one is present. From this value the block derives both the immediate operand address and the sequential successor used by branches. Inherent and immediate requests need no operand bytes, so they finish in the cycle after `start`. A new `start` drops any request that is partly collected.

Top module: `eag_unit`

## Requirements
- R1: Direct mode (mode code 2) takes one operand byte; the effective address is 0x00 in the high byte and the operand byte in the low byte.
- R2: Extended mode (mode code 3) takes two operand bytes; the first accepted byte is the high address byte and the second is the low byte.
- R3: Indexed mode (mode code 4) takes one operand byte, zero-extends it and adds it to `ix` when `idx_sel` is 0 or to `iy` when `idx_sel` is 1, modulo 65536; `idx_sel` has no effect in any other mode.
- R4: Relative mode (mode code 5) takes one operand byte; the successor address is `pc` plus the instruction length; when `br_taken` is 1 the result is the successor plus the sign-extended byte, otherwise it is the successor, modulo 65536.
- R5: Immediate mode (mode code 1) takes no operand bytes, finishes with `done` in the cycle after `start`, and yields `pc` + 1 + prebyte.
- R6: Inherent mode (mode code 0, and the unused codes 6 and 7) finishes with `done` in the cycle after `start`, with `ea` = 0 and `no_addr` = 1; every other mode finishes with `no_addr` = 0.
- R7: `ilen` is the base length plus 1 when `prebyte` is 1. The base lengths are inherent 1, immediate 2 (`imm_wide` = 0) or 3 (`imm_wide` = 1), direct 2, extended 3, indexed 2 and relative 2.
- R8: `done` rises on the clock edge that accepts the last needed operand byte, stays high for exactly one cycle and stays low while bytes are outstanding. `ea`, `ilen` and `no_addr` hold their values until the next `done`. Mode, flags, `pc`, `ix`, `iy` and `br_taken` are sampled only in the `start` cycle.
- R9: `start` discards any partly collected operand bytes. `opnd_valid` has no effect when no request is pending or in a `start` cycle.
- R10: After reset, `done` = 0, `ea` = 0, `ilen` = 0 and `no_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a request; samples the configuration inputs |
| mode | input | 3 | Addressing mode code (0 inh, 1 imm, 2 dir, 3 ext, 4 idx, 5 rel) |
| prebyte | input | 1 | Instruction carries a prebyte |
| imm_wide | input | 1 | Immediate operand is two bytes |
| idx_sel | input | 1 | Index register select: 0 = ix, 1 = iy |
| br_taken | input | 1 | Branch condition is true |
| pc | input | 16 | Address of the instruction's first byte |
| ix | input | 16 | First index register value |
| iy | input | 16 | Second index register value |
| opnd_valid | input | 1 | An operand byte is present on `opnd_byte` |
| opnd_byte | input | 8 | Operand byte |
| ea | output | 16 | Effective address |
| ilen | output | 3 | Instruction length in bytes |
| done | output | 1 | One-cycle completion pulse |
| no_addr | output | 1 | Request produced no memory address |

## Verification
Suppose the byte counter or the stored high byte is corrupted. The fault shows up at the `done` edge of that same request: either `done` fires one byte too early or too late, or an extended address has its bytes swapped or mixed with stale data. A wrong latched mode or flag shows up at that `done` as a bad `ilen` or a bad sum. Carry errors in the index or branch adders appear only when the sum crosses a 256-byte boundary or wraps past 0xFFFF, so the sweeps place the base values next to those boundaries.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [2:0] {
        AM_INH = 3'd0,
        AM_IMM = 3'd1,
        AM_DIR = 3'd2,
        AM_EXT = 3'd3,
        AM_IDX = 3'd4,
        AM_REL = 3'd5
    } amode_e;

    // Codes above the last defined mode behave as inherent.
    function automatic amode_e norm_mode(input logic [2:0] code);
        return (code > 3'd5) ? AM_INH : amode_e'(code);
    endfunction
endpackage

// File: rtl/eag_len.sv
module eag_len
    import eag_pkg::*;
#(
    parameter int LW = 3
) (
    input  amode_e          mode,
    input  logic            pb,
    input  logic            wide,
    output logic [LW-1:0]   len,
    output logic [1:0]      need
);
    logic [LW-1:0] base;

    always_comb begin
        case (mode)
            AM_IMM:  begin base = wide ? LW'(3) : LW'(2); need = 2'd0; end
            AM_DIR:  begin base = LW'(2); need = 2'd1; end
            AM_EXT:  begin base = LW'(3); need = 2'd2; end
            AM_IDX:  begin base = LW'(2); need = 2'd1; end
            AM_REL:  begin base = LW'(2); need = 2'd1; end
            default: begin base = LW'(1); need = 2'd0; end
        endcase
        len = base + LW'(pb);
    end
endmodule

// File: rtl/eag_form.sv
module eag_form
    import eag_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 3,
    localparam int AW = 2 * DW
) (
    input  amode_e          mode,
    input  logic            pb,
    input  logic            sel,
    input  logic            taken,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   ix,
    input  logic [AW-1:0]   iy,
    input  logic [DW-1:0]   hi,
    input  logic [DW-1:0]   lo,
    input  logic [LW-1:0]   len,
    output logic [AW-1:0]   ea,
    output logic            noaddr
);
    logic [AW-1:0] succ;
    logic [AW-1:0] zext;
    logic [AW-1:0] sext;
    logic [AW-1:0] base_reg;

    always_comb begin
        succ     = pc + AW'(len);
        zext     = AW'(lo);
        sext     = {{DW{lo[DW-1]}}, lo};
        base_reg = sel ? iy : ix;
        noaddr   = 1'b0;
        case (mode)
            AM_IMM:  ea = pc + AW'(1) + AW'(pb);
            AM_DIR:  ea = zext;
            AM_EXT:  ea = {hi, lo};
            AM_IDX:  ea = base_reg + zext;
            AM_REL:  ea = taken ? (succ + sext) : succ;
            default: begin ea = '0; noaddr = 1'b1; end
        endcase
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 3,
    localparam int AW = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic            prebyte,
    input  logic            imm_wide,
    input  logic            idx_sel,
    input  logic            br_taken,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   ix,
    input  logic [AW-1:0]   iy,
    input  logic            opnd_valid,
    input  logic [DW-1:0]   opnd_byte,
    output logic [AW-1:0]   ea,
    output logic [LW-1:0]   ilen,
    output logic            done,
    output logic            no_addr
);
    typedef struct packed {
        logic            busy;
        logic [1:0]      got;
        logic [DW-1:0]   hi;
        amode_e          mode;
        logic            pb;
        logic            wide;
        logic            sel;
        logic            taken;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   ix;
        logic [AW-1:0]   iy;
        logic [AW-1:0]   ea;
        logic [LW-1:0]   len;
        logic            done;
        logic            noaddr;
    } st_t;

    st_t s_d, s_q;

    // Request view: live inputs in the start cycle, latched copy afterwards.
    amode_e        cur_mode;
    logic          cur_pb, cur_wide, cur_sel, cur_taken;
    logic [AW-1:0] cur_pc, cur_ix, cur_iy;
    logic [LW-1:0] f_len;
    logic [1:0]    f_need;
    logic [AW-1:0] f_ea;
    logic          f_noaddr;

    always_comb begin
        if (start) begin
            cur_mode  = norm_mode(mode);
            cur_pb    = prebyte;
            cur_wide  = imm_wide;
            cur_sel   = idx_sel;
            cur_taken = br_taken;
            cur_pc    = pc;
            cur_ix    = ix;
            cur_iy    = iy;
        end else begin
            cur_mode  = s_q.mode;
            cur_pb    = s_q.pb;
            cur_wide  = s_q.wide;
            cur_sel   = s_q.sel;
            cur_taken = s_q.taken;
            cur_pc    = s_q.pc;
            cur_ix    = s_q.ix;
            cur_iy    = s_q.iy;
        end
    end

    eag_len #(.LW(LW)) u_len (
        .mode (cur_mode),
        .pb   (cur_pb),
        .wide (cur_wide),
        .len  (f_len),
        .need (f_need)
    );

    eag_form #(.DW(DW), .LW(LW)) u_form (
        .mode   (cur_mode),
        .pb     (cur_pb),
        .sel    (cur_sel),
        .taken  (cur_taken),
        .pc     (cur_pc),
        .ix     (cur_ix),
        .iy     (cur_iy),
        .hi     (s_q.hi),
        .lo     (opnd_byte),
        .len    (f_len),
        .ea     (f_ea),
        .noaddr (f_noaddr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d.mode  = cur_mode;
            s_d.pb    = cur_pb;
            s_d.wide  = cur_wide;
            s_d.sel   = cur_sel;
            s_d.taken = cur_taken;
            s_d.pc    = cur_pc;
            s_d.ix    = cur_ix;
            s_d.iy    = cur_iy;
            s_d.got   = 2'd0;
            s_d.hi    = '0;
            if (f_need == 2'd0) begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.ea     = f_ea;
                s_d.len    = f_len;
                s_d.noaddr = f_noaddr;
            end else begin
                s_d.busy = 1'b1;
            end
        end else if (s_q.busy && opnd_valid) begin
            if (s_q.got + 2'd1 == f_need) begin
                s_d.busy   = 1'b0;
                s_d.got    = 2'd0;
                s_d.done   = 1'b1;
                s_d.ea     = f_ea;
                s_d.len    = f_len;
                s_d.noaddr = f_noaddr;
            end else begin
                s_d.hi  = opnd_byte;
                s_d.got = s_q.got + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ea      = s_q.ea;
    assign ilen    = s_q.len;
    assign done    = s_q.done;
    assign no_addr = s_q.noaddr;

    AST_DIR_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.mode == AM_DIR) |-> (ea[AW-1:DW] == '0)); // R1
    AST_NOADDR_EA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        no_addr |-> (ea == '0)); // R6
    AST_QUICK_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (norm_mode(mode) == AM_INH || norm_mode(mode) == AM_IMM)) |=> done); // R5
    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ilen >= LW'(1) && ilen <= LW'(5))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R8
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !opnd_valid && !start) |=> !done); // R8
    AST_IDLE_BYTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !start) |=> (!done && $stable(ea))); // R9
endmodule

// File: tb/tb_eag_unit.sv
module tb_eag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        prebyte = 1'b0, imm_wide = 1'b0, idx_sel = 1'b0, br_taken = 1'b0;
    logic [15:0] pc = '0, ix = '0, iy = '0;
    logic        opnd_valid = 1'b0;
    logic [7:0]  opnd_byte = '0;
    logic [15:0] ea;
    logic [2:0]  ilen;
    logic        done, no_addr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .prebyte(prebyte), .imm_wide(imm_wide), .idx_sel(idx_sel),
        .br_taken(br_taken), .pc(pc), .ix(ix), .iy(iy),
        .opnd_valid(opnd_valid), .opnd_byte(opnd_byte),
        .ea(ea), .ilen(ilen), .done(done), .no_addr(no_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One full request; expected values follow the requirements directly.
    task automatic do_req(input logic [2:0] m, input logic pb, input logic w,
                          input logic sel, input logic tk,
                          input logic [15:0] p, input logic [15:0] x,
                          input logic [15:0] y, input logic [7:0] b0,
                          input logic [7:0] b1, input int gap, input string req);
        int nb, elen, eea, enoaddr;
        case (m)
            3'd1: begin nb = 0; elen = w ? 3 : 2; end
            3'd2: begin nb = 1; elen = 2; end
            3'd3: begin nb = 2; elen = 3; end
            3'd4: begin nb = 1; elen = 2; end
            3'd5: begin nb = 1; elen = 2; end
            default: begin nb = 0; elen = 1; end
        endcase
        elen = elen + int'(pb);
        enoaddr = 0;
        case (m)
            3'd1: eea = (int'(p) + 1 + int'(pb)) & 16'hFFFF;
            3'd2: eea = int'(b0);
            3'd3: eea = int'(b0) * 256 + int'(b1);
            3'd4: eea = (int'(sel ? y : x) + int'(b0)) & 16'hFFFF;
            3'd5: eea = tk ? ((int'(p) + elen + int'(signed'(b0))) & 16'hFFFF)
                           : ((int'(p) + elen) & 16'hFFFF);
            default: begin eea = 0; enoaddr = 1; end
        endcase

        @(negedge clk);
        start = 1'b1; mode = m; prebyte = pb; imm_wide = w; idx_sel = sel;
        br_taken = tk; pc = p; ix = x; iy = y;
        opnd_valid = 1'b1; opnd_byte = 8'h5A;   // ignored in the start cycle (R9)
        @(negedge clk);
        start = 1'b0; opnd_valid = 1'b0;
        // Scramble configuration: only the start-cycle values may count (R8).
        pc = ~p; ix = ~x; iy = ~y; idx_sel = ~sel; br_taken = ~tk;
        prebyte = ~pb; imm_wide = ~w; mode = 3'd3;
        for (int i = 0; i < nb; i++) begin
            for (int g = 0; g < gap; g++) begin
                chk(done == 1'b0, "R8", "done during gap", int'(done), 0);
                @(negedge clk);
            end
            chk(done == 1'b0, "R8", "done before last byte", int'(done), 0);
            opnd_valid = 1'b1;
            opnd_byte = (i == 0) ? b0 : b1;
            @(negedge clk);
            opnd_valid = 1'b0;
        end
        chk(done == 1'b1, req, "done at finish", int'(done), 1);
        chk(int'(ea) == eea, req, "ea", int'(ea), eea);
        chk(int'(ilen) == elen, "R7", "ilen", int'(ilen), elen);
        chk(int'(no_addr) == enoaddr, "R6", "no_addr", int'(no_addr), enoaddr);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", int'(done), 0);
        chk(int'(ea) == eea, "R8", "ea held", int'(ea), eea);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        failures++;
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
        chk(ea == 16'h0, "R10", "ea in reset", int'(ea), 0);
        chk(ilen == 3'd0, "R10", "ilen in reset", int'(ilen), 0);
        chk(no_addr == 1'b0, "R10", "no_addr in reset", int'(no_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && ea == 16'h0, "R10", "idle after reset", int'(ea), 0);

        // R1: direct sweep, index select toggled to show it has no effect (R3)
        for (int b = 0; b < 256; b++)
            for (int pb = 0; pb < 2; pb++)
                do_req(3'd2, pb[0], 1'b0, b[0], 1'b0, 16'h4000, 16'hFFFF, 16'h8000,
                       b[7:0], 8'h00, b % 2, "R1");

        // R2: extended sweep over both bytes
        for (int h = 0; h < 256; h += 17)
            for (int l = 0; l < 256; l += 13)
                do_req(3'd3, h[0], 1'b0, l[0], 1'b0, 16'h1000, 16'h0, 16'h0,
                       h[7:0], l[7:0], (h + l) % 3, "R2");

        // R3: indexed, base values near carry and wrap boundaries
        for (int k = 0; k < 5; k++) begin
            logic [15:0] base;
            case (k)
                0: base = 16'h0000;
                1: base = 16'h00FF;
                2: base = 16'h12F0;
                3: base = 16'hFF80;
                default: base = 16'hFFFF;
            endcase
            for (int b = 0; b < 256; b += 5)
                for (int s = 0; s < 2; s++)
                    do_req(3'd4, b[1], 1'b0, s[0], 1'b0, 16'h2000,
                           base, base ^ 16'h5555, b[7:0], 8'h00, 0, "R3");
        end

        // R4: relative, taken and not taken, across wrap boundaries
        for (int k = 0; k < 3; k++) begin
            logic [15:0] p;
            case (k)
                0: p = 16'h0000;
                1: p = 16'hFFFD;
                default: p = 16'h80F0;
            endcase
            for (int b = 0; b < 256; b++)
                for (int t = 0; t < 2; t++)
                    do_req(3'd5, b[0], 1'b0, b[1], t[0], p, 16'h0, 16'h0,
                           b[7:0], 8'h00, 0, "R4");
        end

        // R5: immediate, both widths and prebyte, including wrap
        for (int k = 0; k < 4; k++)
            for (int w = 0; w < 2; w++)
                for (int pb = 0; pb < 2; pb++)
                    do_req(3'd1, pb[0], w[0], 1'b1, 1'b1,
                           (k == 3) ? 16'hFFFF : 16'(k * 16'h3333),
                           16'h0, 16'h0, 8'h00, 8'h00, 0, "R5");

        // R6: inherent and the unused codes
        for (int m = 0; m < 8; m += 1)
            if (m == 0 || m >= 6)
                for (int pb = 0; pb < 2; pb++)
                    do_req(m[2:0], pb[0], 1'b1, 1'b1, 1'b1, 16'hABCD, 16'h1, 16'h2,
                           8'h77, 8'h88, 0, "R6");

        // R9: abandoned extended request, then a fresh one
        @(negedge clk);
        start = 1'b1; mode = 3'd3; prebyte = 1'b0; pc = 16'h0;
        @(negedge clk);
        start = 1'b0; opnd_valid = 1'b1; opnd_byte = 8'hEE;
        @(negedge clk);
        opnd_valid = 1'b0;
        chk(done == 1'b0, "R9", "done after one of two bytes", int'(done), 0);
        do_req(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0,
               8'h12, 8'h34, 0, "R9");
        @(negedge clk);
        start = 1'b1; mode = 3'd3;
        @(negedge clk);
        start = 1'b0; opnd_valid = 1'b1; opnd_byte = 8'hDD;
        @(negedge clk);
        opnd_valid = 1'b0;
        do_req(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0,
               8'h9C, 8'h00, 0, "R9");

        // R9: stray bytes while idle change nothing
        for (int i = 0; i < 6; i++) begin
            opnd_valid = 1'b1; opnd_byte = 8'(i * 41);
            @(negedge clk);
            chk(done == 1'b0, "R9", "idle byte done", int'(done), 0);
            chk(ea == 16'h009C, "R9", "idle byte ea", int'(ea), 16'h009C);
        end
        opnd_valid = 1'b0;

        summary();
        $finish;
    end
endmodule